// File: doc/BRIEF.md
# Multicycle RISC Instruction Sequencer

This block executes a 32-bit fixed-format, three-operand RISC instruction set one instruction at a time. A controller walks each instruction through a short chain of named states: fetch, decode, then a class-specific sequence. Each state drives explicit control points on a small datapath. That datapath holds the program counter, the instruction register, two operand latches, an ALU result register, a write-back register and a 32-entry register file.

All instruction and data traffic goes through one memory port with a valid/ready handshake. The block raises `mem_req` together with the address, the write enable and the write data. It holds all of them unchanged until the memory answers with `mem_rdy` high in some cycle. The transfer completes in that cycle and read data is sampled in that same cycle. The memory may apply back-pressure by holding `mem_rdy` low for any number of cycles, and the sequencer simply stays in the requesting state.

The supported classes are register-register ALU, register-immediate ALU, load, store, conditional branch on zero or non-zero, and jump.

Top module: `seqcpu_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, the block requests an instruction fetch at address 0 with `mem_we` low; the program counter resets to 0.
- R2: An instruction fetch reads the word at the program counter into the instruction register and advances the program counter by 4. Straight-line code is fetched from consecutive word addresses.
- R3: Once `mem_req` is high, `mem_addr`, `mem_we` and `mem_wdata` stay stable until a cycle with `mem_rdy` high. A state that owns a memory access lasts 1 + (number of cycles `mem_rdy` was held low).
- R4: Instruction fields are laid out as follows. Opcode is bits 31:26 and rs is bits 25:21. The second register is bits 20:16; it is the source rt, or the destination of immediate and load instructions. In register-register instructions, rd is bits 15:11 and the function code is bits 10:0. The immediate is bits 15:0. The jump target is bits 25:0.
- R5: Opcode 0x00 writes rd with A op B, where A comes from rs and B from rt. The function codes are: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, and 5 set-if-less-than signed, which gives 1 or 0.
- R6: The register-immediate opcodes each combine A with the sign-extended immediate and write the result to register bits 20:16. They are: 0x08 add, 0x0A signed set-if-less-than, 0x0C AND, 0x0D OR, 0x0E XOR.
- R7: Load (opcode 0x23) reads the word at A + sign-extended immediate and writes it to register bits 20:16.
- R8: Store (opcode 0x2B) writes register rt to address A + sign-extended immediate and changes no register.
- R9: Opcode 0x04 branches when A is zero and opcode 0x05 branches when A is non-zero. The target is (address of branch + 4) + (sign-extended immediate × 4). An untaken branch continues with the next word.
- R10: Jump (opcode 0x02) sets the program counter to the upper 4 bits of (jump address + 4), followed by the 26-bit target, followed by two zero bits.
- R11: Register 0 always reads as zero; writes to it are discarded.
- R12: With no wait cycles, instructions take the following numbers of cycles from fetch to the next fetch. ALU instructions (both forms) take 5. Load takes 5, store takes 4, and branch and jump take 3. Each wait cycle on any access adds one.
- R13: An opcode not listed above changes no register or memory and returns to fetch after decode, taking 2 cycles plus fetch waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory request valid |
| mem_rdy | input | 1 | Memory ready; completes the current request |
| mem_we | output | 1 | Request is a write (store) |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the cycle `mem_rdy` is high |

## Verification
Two events can coincide in one cycle: the completion of a memory handshake, and the state advance that latches its data and moves the program counter. When ready arrives in the very cycle the request appears, the fetch, the PC increment and the move to decode all happen at one edge. A store completion can also be followed at once by the next fetch request. The bench sweeps a memory model whose ready latency is 0, 1, 2 or 3 cycles across ALU, load, store, branch, jump and undefined-opcode programs. It judges each case by the stored results, by the order of fetch addresses, and by the cycle distance between consecutive fetch handshakes, computed from the per-class cycle counts.

// File: rtl/seqcpu_pkg.sv
package seqcpu_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned FN_W   = 11;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned TGT_W  = 26;

  localparam logic [OPC_W-1:0] OPC_RR    = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BRZ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BRNZ  = 6'h05;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0E;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
  } alu_op_e;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_EXE_RR, ST_EXE_RI, ST_ADDR,
    ST_LOAD, ST_STORE, ST_XFER, ST_WRITE, ST_BRANCH, ST_JUMP
  } seq_state_e;

  typedef enum logic [1:0] {
    PCS_HOLD, PCS_SEQ, PCS_BRANCH, PCS_JUMP
  } pc_src_e;

  // control points driven by the sequencer each cycle
  typedef struct packed {
    logic    ir_load;
    pc_src_e pc_src;
    logic    ab_load;
    logic    r_load;
    logic    use_imm;
    alu_op_e alu_op;
    logic    wb_load;
    logic    wb_from_mem;
    logic    rf_we;
    logic    dst_rd;
    logic    mem_req;
    logic    mem_we;
    logic    addr_from_r;
  } ctl_t;

  function automatic alu_op_e rr_alu(input logic [FN_W-1:0] fn);
    alu_op_e op;
    case (fn)
      11'd1:   op = ALU_SUB;
      11'd2:   op = ALU_AND;
      11'd3:   op = ALU_OR;
      11'd4:   op = ALU_XOR;
      11'd5:   op = ALU_SLT;
      default: op = ALU_ADD;
    endcase
    return op;
  endfunction

  function automatic alu_op_e ri_alu(input logic [OPC_W-1:0] opc);
    alu_op_e op;
    case (opc)
      OPC_SLTI: op = ALU_SLT;
      OPC_ANDI: op = ALU_AND;
      OPC_ORI:  op = ALU_OR;
      OPC_XORI: op = ALU_XOR;
      default:  op = ALU_ADD;
    endcase
    return op;
  endfunction

  function automatic seq_state_e dispatch(input logic [OPC_W-1:0] opc);
    seq_state_e n;
    case (opc)
      OPC_RR:                                        n = ST_EXE_RR;
      OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_XORI: n = ST_EXE_RI;
      OPC_LOAD, OPC_STORE:                           n = ST_ADDR;
      OPC_BRZ, OPC_BRNZ:                             n = ST_BRANCH;
      OPC_JMP:                                       n = ST_JUMP;
      default:                                       n = ST_FETCH;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/seqcpu_regfile.sv
module seqcpu_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 5,
  parameter int unsigned NRD  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][XLEN-1:0] rd_data,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [XLEN-1:0]          wr_data
);
  localparam int unsigned NREG = 1 << AW;

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en && (wr_addr != '0)) begin
      regs[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = regs[rd_addr[p]];
  end

  AST_ZERO_REG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0); // R11

endmodule

// File: rtl/seqcpu_alu.sv
module seqcpu_alu
  import seqcpu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  logic lt;
  assign lt = $signed(a) < $signed(b);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, lt};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/seqcpu_ctrl.sv
module seqcpu_ctrl
  import seqcpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opc,
  input  logic [FN_W-1:0]  fn,
  input  logic             a_zero,
  input  logic             mem_rdy,
  output seq_state_e       state,
  output ctl_t             ctl
);
  seq_state_e state_q, state_d;
  logic       br_take;

  assign state   = state_q;
  assign br_take = (opc == OPC_BRZ) ? a_zero : !a_zero;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH;
    else     state_q <= state_d;
  end

  always_comb begin
    ctl         = '0;
    ctl.pc_src  = PCS_HOLD;
    ctl.alu_op  = ALU_ADD;
    state_d     = state_q;
    unique case (state_q)
      ST_FETCH: begin
        ctl.mem_req = 1'b1;
        if (mem_rdy) begin
          ctl.ir_load = 1'b1;
          ctl.pc_src  = PCS_SEQ;
          state_d     = ST_DECODE;
        end
      end
      ST_DECODE: begin
        ctl.ab_load = 1'b1;
        state_d     = dispatch(opc);
      end
      ST_EXE_RR: begin
        ctl.r_load = 1'b1;
        ctl.alu_op = rr_alu(fn);
        state_d    = ST_XFER;
      end
      ST_EXE_RI: begin
        ctl.r_load  = 1'b1;
        ctl.use_imm = 1'b1;
        ctl.alu_op  = ri_alu(opc);
        state_d     = ST_XFER;
      end
      ST_ADDR: begin
        ctl.r_load  = 1'b1;
        ctl.use_imm = 1'b1;
        state_d     = (opc == OPC_LOAD) ? ST_LOAD : ST_STORE;
      end
      ST_LOAD: begin
        ctl.mem_req     = 1'b1;
        ctl.addr_from_r = 1'b1;
        if (mem_rdy) begin
          ctl.wb_load     = 1'b1;
          ctl.wb_from_mem = 1'b1;
          state_d         = ST_WRITE;
        end
      end
      ST_STORE: begin
        ctl.mem_req     = 1'b1;
        ctl.mem_we      = 1'b1;
        ctl.addr_from_r = 1'b1;
        if (mem_rdy) state_d = ST_FETCH;
      end
      ST_XFER: begin
        ctl.wb_load = 1'b1;
        state_d     = ST_WRITE;
      end
      ST_WRITE: begin
        ctl.rf_we  = 1'b1;
        ctl.dst_rd = (opc == OPC_RR);
        state_d    = ST_FETCH;
      end
      ST_BRANCH: begin
        if (br_take) ctl.pc_src = PCS_BRANCH;
        state_d = ST_FETCH;
      end
      ST_JUMP: begin
        ctl.pc_src = PCS_JUMP;
        state_d    = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  AST_WAIT_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    (ctl.mem_req && !mem_rdy) |=> (state_q == $past(state_q))); // R3

  AST_STORE_DONE_FETCH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STORE && mem_rdy) |=> (state_q == ST_FETCH)); // R8

endmodule

// File: rtl/seqcpu_top.sv
module seqcpu_top
  import seqcpu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RF_AW = 5
) (
  input  logic            clk,
  input  logic            rst,
  output logic            mem_req,
  input  logic            mem_rdy,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata
);
  localparam int unsigned PC_HI_LSB = TGT_W + 2;

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, r_q, wb_q;
  logic [XLEN-1:0] imm_sx, alu_b, alu_y, pc_br, pc_jmp;
  logic [OPC_W-1:0] opc;
  logic [RF_AW-1:0] f_rs, f_rt, f_rd, wr_sel;
  logic [FN_W-1:0]  f_fn;
  logic [IMM_W-1:0] f_imm;
  logic [TGT_W-1:0] f_tgt;
  logic [1:0][RF_AW-1:0] rf_ra;
  logic [1:0][XLEN-1:0]  rf_rd;
  logic       a_zero;
  ctl_t       ctl;
  seq_state_e state;

  // instruction field slicing
  assign opc   = ir_q[31:26];
  assign f_rs  = ir_q[25:21];
  assign f_rt  = ir_q[20:16];
  assign f_rd  = ir_q[15:11];
  assign f_fn  = ir_q[FN_W-1:0];
  assign f_imm = ir_q[IMM_W-1:0];
  assign f_tgt = ir_q[TGT_W-1:0];

  assign imm_sx = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
  assign a_zero = (a_q == '0);
  assign pc_br  = pc_q + (imm_sx << 2);
  assign pc_jmp = {pc_q[XLEN-1:PC_HI_LSB], f_tgt, 2'b00};
  assign alu_b  = ctl.use_imm ? imm_sx : b_q;

  seqcpu_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opc     (opc),
    .fn      (f_fn),
    .a_zero  (a_zero),
    .mem_rdy (mem_rdy),
    .state   (state),
    .ctl     (ctl)
  );

  seqcpu_alu #(.XLEN(XLEN)) u_alu (
    .op (ctl.alu_op),
    .a  (a_q),
    .b  (alu_b),
    .y  (alu_y)
  );

  assign rf_ra[0] = f_rs;
  assign rf_ra[1] = f_rt;
  assign wr_sel   = ctl.dst_rd ? f_rd : f_rt;

  seqcpu_regfile #(.XLEN(XLEN), .AW(RF_AW), .NRD(2)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rf_ra),
    .rd_data (rf_rd),
    .wr_en   (ctl.rf_we),
    .wr_addr (wr_sel),
    .wr_data (wb_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      r_q  <= '0;
      wb_q <= '0;
    end else begin
      if (ctl.ir_load) ir_q <= mem_rdata;
      unique case (ctl.pc_src)
        PCS_SEQ:    pc_q <= pc_q + XLEN'(4);
        PCS_BRANCH: pc_q <= pc_br;
        PCS_JUMP:   pc_q <= pc_jmp;
        default:    pc_q <= pc_q;
      endcase
      if (ctl.ab_load) begin
        a_q <= rf_rd[0];
        b_q <= rf_rd[1];
      end
      if (ctl.r_load)  r_q  <= alu_y;
      if (ctl.wb_load) wb_q <= ctl.wb_from_mem ? mem_rdata : r_q;
    end
  end

  assign mem_req   = ctl.mem_req;
  assign mem_we    = ctl.mem_we;
  assign mem_addr  = ctl.addr_from_r ? r_q : pc_q;
  assign mem_wdata = b_q;

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata))); // R3

  AST_FETCH_ADVANCES_PC: assert property (@(posedge clk) disable iff (rst)
    ctl.ir_load |=> (pc_q == $past(pc_q) + XLEN'(4))); // R2

  AST_DECODE_KEEPS_PC: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE) |=> $stable(pc_q)); // R2

  AST_BRANCH_UNTAKEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BRANCH && ((opc == OPC_BRZ) != a_zero)) |=> $stable(pc_q)); // R9

endmodule

// File: tb/test_seqcpu_top.sv
module test_seqcpu_top;
  localparam int MW = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req, mem_we, mem_rdy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  seqcpu_top i_seqcpu_top (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_rdy   (mem_rdy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  logic [31:0] img [MW];
  logic [31:0] mem [MW];
  int lat = 0, cnt = 0, cyc = 0, fidx = 0, halt_w = 0, halt_cyc = 0;
  bit hit = 0;
  int fcyc [512];
  logic [31:0] faddr [512];
  int n_chk = 0, n_bad = 0;

  // memory model: responds at the falling edge after lat wait cycles
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      for (int i = 0; i < MW; i++) mem[i] = img[i];
      mem_rdy = 1'b0; mem_rdata = '0; cnt = 0; fidx = 0; hit = 0; halt_cyc = 0;
    end else begin
      if (mem_rdy) begin mem_rdy = 1'b0; cnt = 0; end
      if (mem_req) begin
        if (cnt >= lat) begin
          mem_rdy = 1'b1;
          if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
          else begin
            mem_rdata = mem[mem_addr[9:2]];
            if (mem_addr < 32'h200 && fidx < 512) begin
              fcyc[fidx] = cyc; faddr[fidx] = mem_addr; fidx = fidx + 1;
            end
            if (!hit && mem_addr == 32'(halt_w * 4)) begin hit = 1; halt_cyc = cyc; end
          end
        end else cnt = cnt + 1;
      end
    end
  end

  function automatic logic [31:0] e_rr(int fn, int rs, int rt, int rd);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], fn[10:0]};
  endfunction
  function automatic logic [31:0] e_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] e_j(int t);
    return {6'h02, t[25:0]};
  endfunction
  function automatic logic [31:0] ref_op(int k, logic [31:0] a, logic [31:0] b);
    case (k)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic clear_img();
    for (int i = 0; i < MW; i++) img[i] = 32'hC0DE0000 | 32'(i);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start(int l, int hw);
    lat = l; halt_w = hw;
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic finish_run();
    int w = 0;
    while (!hit && w < 20000) begin @(posedge clk); w++; end
    if (!hit) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual no halt fetch expected halt at word %0d", halt_w);
    end
    repeat (2) @(posedge clk);
  endtask

  logic [31:0] av [8] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                          32'hFFFFFFFF, 32'h12345678, 32'h5, 32'hFFFF0000};
  logic [31:0] bv [8] = '{32'h0, 32'hFFFFFFFF, 32'h1, 32'h80000000,
                          32'hFFFFFFFF, 32'h9ABCDEF0, 32'h7, 32'h0000FFFF};
  logic [15:0] iv [8] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF,
                          16'h0001, 16'h1234, 16'hFFFB, 16'h00F0};
  logic [5:0] ri_opc [5] = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E};
  int         ri_k   [5] = '{0, 5, 2, 3, 4};

  task automatic t_alu(int p, int l);
    logic [31:0] a, b, ix;
    a = av[p]; b = bv[p]; ix = {{16{iv[p][15]}}, iv[p]};
    clear_img();
    img[128] = a; img[129] = b;
    img[0] = e_i(6'h23, 0, 1, 16'h0200);
    img[1] = e_i(6'h23, 0, 2, 16'h0204);
    for (int k = 0; k < 6; k++) img[2 + k] = e_rr(k, 1, 2, 3 + k);
    for (int j = 0; j < 5; j++) img[8 + j] = e_i(ri_opc[j], 1, 9 + j, iv[p]);
    for (int s = 0; s < 11; s++) img[13 + s] = e_i(6'h2B, 0, 3 + s, 16'(32'h300 + 4 * s));
    img[24] = e_i(6'h2B, 0, 1, 16'h0340);
    img[25] = e_i(6'h2B, 0, 2, 16'h0344);
    img[26] = e_j(26);
    start(l, 26);
    finish_run();
    for (int k = 0; k < 6; k++) chk("R5 R4 register-register result", mem[192 + k], ref_op(k, a, b));
    for (int j = 0; j < 5; j++) chk("R6 register-immediate result", mem[198 + j], ref_op(ri_k[j], a, ix));
    chk("R7 load then store of first operand", mem[208], a);
    chk("R7 load then store of second operand", mem[209], b);
    for (int i = 0; i < 27; i++) chk("R2 sequential fetch address", faddr[i], 32'(4 * i));
    chk("R12 R3 cycles from first fetch to halt", 32'(halt_cyc - fcyc[0]),
        32'(2 * (5 + 2 * l) + 11 * (5 + l) + 13 * (4 + 2 * l)));
  endtask

  task automatic t_r0();
    clear_img();
    img[0] = e_i(6'h08, 0, 1, 16'd7);
    img[1] = e_i(6'h08, 1, 0, 16'd9);
    img[2] = e_rr(0, 1, 1, 0);
    img[3] = e_i(6'h2B, 0, 0, 16'h0300);
    img[4] = e_rr(0, 0, 1, 2);
    img[5] = e_i(6'h2B, 0, 2, 16'h0304);
    img[6] = e_j(6);
    start(0, 6);
    finish_run();
    chk("R11 register 0 after writes", mem[192], 32'd0);
    chk("R11 register 0 read as operand", mem[193], 32'd7);
  endtask

  task automatic t_branch(int l);
    int exp_tr [15] = '{0, 1, 2, 3, 1, 2, 3, 1, 2, 3, 4, 6, 7, 8, 9};
    clear_img();
    img[0] = e_i(6'h08, 0, 1, 16'd3);
    img[1] = e_i(6'h08, 2, 2, 16'd1);
    img[2] = e_i(6'h08, 1, 1, 16'hFFFF);
    img[3] = e_i(6'h05, 1, 0, 16'hFFFD);
    img[4] = e_i(6'h04, 0, 0, 16'h0001);
    img[5] = e_i(6'h08, 2, 2, 16'd100);
    img[6] = e_i(6'h05, 0, 0, 16'h0005);
    img[7] = e_i(6'h08, 2, 2, 16'd16);
    img[8] = e_i(6'h2B, 0, 2, 16'h0300);
    img[9] = e_j(9);
    start(l, 9);
    finish_run();
    for (int i = 0; i < 15; i++) chk("R9 branch fetch order", faddr[i], 32'(4 * exp_tr[i]));
    chk("R9 loop result", mem[192], 32'd19);
    chk("R12 branch cycles", 32'(fcyc[4] - fcyc[3]), 32'(3 + l));
  endtask

  task automatic t_jump(int l);
    int exp_tr [5] = '{0, 5, 6, 7, 8};
    clear_img();
    img[0] = e_j(5);
    img[1] = e_i(6'h08, 0, 1, 16'd1);
    img[5] = e_i(6'h08, 0, 2, 16'h002A);
    img[6] = e_i(6'h2B, 0, 2, 16'h0300);
    img[7] = e_i(6'h2B, 0, 1, 16'h0304);
    img[8] = e_j(8);
    start(l, 8);
    finish_run();
    for (int i = 0; i < 5; i++) chk("R10 jump fetch order", faddr[i], 32'(4 * exp_tr[i]));
    chk("R10 jump target code ran", mem[192], 32'h2A);
    chk("R10 skipped code had no effect", mem[193], 32'd0);
    chk("R12 jump cycles", 32'(fcyc[1] - fcyc[0]), 32'(3 + l));
  endtask

  task automatic t_store_undef(int l);
    clear_img();
    img[0] = e_i(6'h08, 0, 5, 16'h0077);
    img[1] = e_i(6'h08, 0, 6, 16'h0310);
    img[2] = e_i(6'h2B, 6, 5, 16'hFFF8);
    img[3] = e_i(6'h3F, 0, 5, 16'h0001);
    img[4] = e_i(6'h2B, 0, 5, 16'h0300);
    img[5] = e_i(6'h23, 6, 7, 16'hFFFC);
    img[6] = e_i(6'h2B, 0, 7, 16'h0304);
    img[7] = e_j(7);
    start(l, 7);
    finish_run();
    chk("R8 store with negative displacement", mem[194], 32'h77);
    chk("R13 R8 source register unchanged", mem[192], 32'h77);
    chk("R7 load with negative displacement", mem[193], 32'hC0DE00C3);
    chk("R12 R8 store cycles", 32'(fcyc[3] - fcyc[2]), 32'(4 + 2 * l));
    chk("R13 undefined opcode cycles", 32'(fcyc[4] - fcyc[3]), 32'(2 + l));
  endtask

  initial begin
    // reset state
    clear_img();
    img[0] = e_j(0);
    lat = 0; halt_w = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    chk("R1 request out of reset", 32'(mem_req), 32'd1);
    chk("R1 write enable out of reset", 32'(mem_we), 32'd0);
    chk("R1 first fetch address", mem_addr, 32'd0);
    finish_run();
    chk("R1 first handshake address", faddr[0], 32'd0);

    for (int l = 0; l < 3; l++)
      for (int p = 0; p < 8; p++) t_alu(p, l);
    t_r0();
    t_branch(0);
    t_branch(2);
    t_jump(0);
    t_jump(3);
    t_store_undef(1);
    t_store_undef(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule